// File: doc/BRIEF.md
# Dual-Channel Angle Hold Latch with Shared Byte Bus

This block takes the running angle words of two independent tracking counters and presents them on one shared tri-state data bus. Each channel keeps its own output register. A single active-low hold input, common to both channels, controls those registers. While hold is high, each register copies its counter on every clock edge. While hold is low, both registers freeze, so software can read a stable angle while the counters go on tracking.

The bus is split into an upper byte lane, which carries the most significant half of the angle, and a lower byte lane. Each channel has one active-low enable for each lane. An enable is registered, so the lane starts or stops driving one clock after the enable changes. When both channels enable the same lane at the same time, the lane is left floating and a clash flag is raised for that lane. The bus is never driven by both channels at once. The angle is natural binary in positive logic, with the top bit worth a half turn.

Top module: `dual_angle_bus_latch`

## Requirements
- R1: While `hold_n` is 1 at a rising clock edge, each channel register loads its counter value on that edge.
- R2: While `hold_n` is 0, both channel registers keep their value across any number of edges, whatever the counters do.
- R3: On the first edge after `hold_n` returns to 1, each register reloads the current counter value.
- R4: The upper lane is `data_bus[W-1:W/2]`. In the cycle after exactly one channel's upper enable is sampled at 0, this lane carries that channel's register bits `[W-1:W/2]`, and `lane_oe[1]` is 1.
- R5: The lower lane is `data_bus[W/2-1:0]`. In the cycle after exactly one channel's lower enable is sampled at 0, this lane carries that channel's register bits `[W/2-1:0]`, and `lane_oe[0]` is 1.
- R6: In the cycle after both enables of a lane are sampled at 1, that lane is high impedance and its `lane_oe` bit is 0.
- R7: In the cycle after both channels' enables for the same lane are sampled at 0, that lane's `lane_clash` bit is 1, the lane is high impedance and its `lane_oe` bit is 0.
- R8: During reset and after it, both registers hold 0 until they are loaded, and `lane_oe` and `lane_clash` are 0 while reset is active.
- R9: The two lanes are steered independently, so one channel can drive the upper lane in the same cycle that the other channel drives the lower lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n | input | 1 | Common hold: 0 freezes both registers, 1 lets them follow their counters |
| cnt_a | input | W | Counter angle, channel A |
| cnt_b | input | W | Counter angle, channel B |
| a_hi_en_n | input | 1 | Channel A upper-lane enable, active low |
| a_lo_en_n | input | 1 | Channel A lower-lane enable, active low |
| b_hi_en_n | input | 1 | Channel B upper-lane enable, active low |
| b_lo_en_n | input | 1 | Channel B lower-lane enable, active low |
| data_bus | inout | W | Shared tri-state angle bus |
| lane_oe | output | 2 | Lane is driven (bit 1 upper, bit 0 lower) |
| lane_clash | output | 2 | Both channels requested the lane (bit 1 upper, bit 0 lower) |

## Verification
Directed sequences cover four cases. A hold that is kept for several cycles while both counters change shows that the register is separate from the counter. Releasing the hold shows that the register reloads on the first edge. A read right after reset separates the reset value from a loaded value. Split-lane and same-lane enable patterns tell correct steering apart from contention. Random runs then vary the hold level and all four enables on every cycle, with fresh counter values each time. This catches a lane that is wired to the wrong channel or the wrong half, and an enable that is not delayed by exactly one cycle.

// File: rtl/dual_angle_bus_latch.sv
module dual_angle_bus_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_n,
  input  logic [W-1:0] cnt_a,
  input  logic [W-1:0] cnt_b,
  input  logic         a_hi_en_n,
  input  logic         a_lo_en_n,
  input  logic         b_hi_en_n,
  input  logic         b_lo_en_n,
  inout  wire  [W-1:0] data_bus,
  output logic [1:0]   lane_oe,
  output logic [1:0]   lane_clash
);
  localparam int H = W / 2;

  logic [W-1:0] lat_a, lat_b;
  logic [1:0]   sel_a, sel_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a <= '0;
      lat_b <= '0;
    end else if (hold_n) begin
      lat_a <= cnt_a;
      lat_b <= cnt_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_a <= '0;
      sel_b <= '0;
    end else begin
      sel_a <= {~a_hi_en_n, ~a_lo_en_n};
      sel_b <= {~b_hi_en_n, ~b_lo_en_n};
    end
  end

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [H-1:0] lane_val;
    assign lane_clash[l] = sel_a[l] & sel_b[l];
    assign lane_oe[l]    = sel_a[l] ^ sel_b[l];
    assign lane_val      = sel_a[l] ? lat_a[l*H +: H] : lat_b[l*H +: H];
    assign data_bus[l*H +: H] = lane_oe[l] ? lane_val : {H{1'bz}};
  end
endmodule

// File: rtl/dual_angle_bus_latch_chk.sv
module dual_angle_bus_latch_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hold_n,
  input logic [W-1:0] cnt_a,
  input logic [W-1:0] cnt_b,
  input logic         a_hi_en_n,
  input logic         a_lo_en_n,
  input logic         b_hi_en_n,
  input logic         b_lo_en_n,
  input logic [W-1:0] data_bus,
  input logic [1:0]   lane_oe,
  input logic [1:0]   lane_clash,
  input logic [W-1:0] lat_a,
  input logic [W-1:0] lat_b
);
  localparam int H = W / 2;

  AST_FOLLOW_COUNTER: assert property (@(posedge clk) disable iff (!rst_n)
    hold_n |=> (lat_a == $past(cnt_a)) && (lat_b == $past(cnt_b))); // R1

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> $stable(lat_a) && $stable(lat_b)); // R2

  AST_UPPER_FROM_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_hi_en_n && b_hi_en_n) |=> lane_oe[1] && (data_bus[W-1:H] == lat_a[W-1:H])); // R4

  AST_LOWER_FROM_B: assert property (@(posedge clk) disable iff (!rst_n)
    (a_lo_en_n && !b_lo_en_n) |=> lane_oe[0] && (data_bus[H-1:0] == lat_b[H-1:0])); // R5

  AST_IDLE_LANE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hi_en_n && b_hi_en_n) |=> !lane_oe[1] && !lane_clash[1]); // R6

  AST_CLASH_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_lo_en_n && !b_lo_en_n) |=> lane_clash[0] && !lane_oe[0]); // R7

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (lane_oe == 2'b00 && lane_clash == 2'b00); // R8
    end
  end
endmodule

bind dual_angle_bus_latch dual_angle_bus_latch_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .cnt_a(cnt_a), .cnt_b(cnt_b),
  .a_hi_en_n(a_hi_en_n), .a_lo_en_n(a_lo_en_n),
  .b_hi_en_n(b_hi_en_n), .b_lo_en_n(b_lo_en_n),
  .data_bus(data_bus), .lane_oe(lane_oe), .lane_clash(lane_clash),
  .lat_a(lat_a), .lat_b(lat_b)
);

// File: tb/dual_angle_bus_latch_test.sv
`timescale 1ns/1ps
module dual_angle_bus_latch_test;
  localparam int W = 16;
  localparam int H = W / 2;

  logic clk = 0, rst_n = 0, hold_n = 1;
  logic [W-1:0] cnt_a = '0, cnt_b = '0;
  logic a_hi_en_n = 1, a_lo_en_n = 1, b_hi_en_n = 1, b_lo_en_n = 1;
  wire  [W-1:0] data_bus;
  logic [1:0] lane_oe, lane_clash;

  int total = 0, bad = 0;
  bit done = 0;
  logic [W-1:0] ea = '0, eb = '0;
  logic [1:0] esa = '0, esb = '0;

  always #5 clk = ~clk;

  dual_angle_bus_latch #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .a_hi_en_n(a_hi_en_n), .a_lo_en_n(a_lo_en_n),
    .b_hi_en_n(b_hi_en_n), .b_lo_en_n(b_lo_en_n),
    .data_bus(data_bus), .lane_oe(lane_oe), .lane_clash(lane_clash)
  );

  task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [H-1:0] lane_of(logic [W-1:0] v, int l);
    return v[l*H +: H];
  endfunction

  task automatic step(string ctx);
    @(posedge clk);
    if (hold_n) begin ea = cnt_a; eb = cnt_b; end
    esa = {~a_hi_en_n, ~a_lo_en_n};
    esb = {~b_hi_en_n, ~b_lo_en_n};
    @(negedge clk);
    for (int l = 0; l < 2; l++) begin
      logic eo, ec;
      string t;
      eo = esa[l] ^ esb[l];
      ec = esa[l] & esb[l];
      t = ec ? "R7" : (!eo ? "R6" : (l == 1 ? "R4" : "R5"));
      chk(lane_oe[l] == eo, t, W'(lane_oe[l]), W'(eo));
      chk(lane_clash[l] == ec, "R7", W'(lane_clash[l]), W'(ec));
      if (eo) begin
        logic [H-1:0] ev, av;
        ev = esa[l] ? lane_of(ea, l) : lane_of(eb, l);
        av = data_bus[l*H +: H];
        chk(av == ev, ctx, W'(av), W'(ev));
      end
    end
  endtask

  task automatic drive(logic h, logic [W-1:0] ca, logic [W-1:0] cb, logic [3:0] en);
    hold_n = h; cnt_a = ca; cnt_b = cb;
    {a_hi_en_n, a_lo_en_n, b_hi_en_n, b_lo_en_n} = en;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(lane_oe == 2'b00, "R8", W'(lane_oe), '0);
    chk(lane_clash == 2'b00, "R8", W'(lane_clash), '0);
    rst_n = 1;
    // R8: hold low straight after reset, channel A reads reset value
    drive(0, 16'hBEEF, 16'h1357, 4'b0011);
    step("R8");
    step("R8");
    // R1: follow counters
    drive(1, 16'h1234, 16'hA5C3, 4'b0011);
    step("R1");
    step("R1");
    // R2: freeze while counters move
    drive(0, 16'h4321, 16'h0F0F, 4'b1100);
    step("R2");
    for (int i = 0; i < 4; i++) begin
      drive(0, W'($urandom), W'($urandom), (i % 2 == 0) ? 4'b1100 : 4'b0011);
      step("R2");
    end
    // R3: release reloads on first edge
    drive(1, 16'h7E81, 16'h9001, 4'b0011);
    step("R3");
    drive(1, 16'h7E81, 16'h9001, 4'b1100);
    step("R3");
    // R5: lower lane from A only
    drive(1, 16'h00FF, 16'hFF00, 4'b1011);
    step("R5");
    // R9: A upper, B lower
    drive(1, 16'hC0DE, 16'hF00D, 4'b0110);
    step("R9");
    drive(0, 16'h0000, 16'h0000, 4'b1001);
    step("R9");
    // R7: clash on upper, then both lanes
    drive(1, 16'h1111, 16'h2222, 4'b0101);
    step("R7");
    drive(1, 16'h3333, 16'h4444, 4'b0000);
    step("R7");
    // R6: all off
    drive(1, 16'h5555, 16'h6666, 4'b1111);
    step("R6");
    for (int i = 0; i < 400; i++) begin
      drive(($urandom % 4) != 0, W'($urandom), W'($urandom), 4'($urandom));
      step("R4");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule